// File: doc/BRIEF.md
# Translation Fault Exception Context Unit

This unit records what a miss handler needs when an address translation goes wrong. Software loads a page-table base into the upper bits of a context word. On a fault, hardware fills the middle bits with the faulting virtual page number. The context word can then be used directly as a pointer to the even member of a 16-byte-aligned even/odd pair of 8-byte page-table entries. The unit also keeps a copy of the faulting virtual address.

The unit holds an exception-level flag. It loads the exception PC only when no exception is already being handled. A refill fault taken at base level branches to the refill vector. Every other fault, and any refill taken while the flag is already set, branches to the general vector. Because a nested refill leaves the exception PC untouched, the return after a nested page-table miss goes back to the instruction that faulted first, and that instruction then retries.

Each fault is a one-cycle input strobe with its virtual address and PC. An exception-return strobe clears the flag.

Top module: `tlb_fault_ctx`

## Requirements
- R1: After reset the context word, bad-address word and exception PC are all zero, and the exception-level flag is 0.
- R2: A software context write changes only context bits 31:23, loaded from the written data's bits 31:23. Bits 22:4 keep their value and bits 3:0 stay zero. A software write and a fault in the same cycle each update their own field.
- R3: A refill, invalid or modified fault loads virtual address bits 31:13 into context bits 22:4 at the next clock edge. The base bits are unchanged and bits 3:0 remain zero.
- R4: When an address-error fault is the selected fault, context bits 22:4 are not changed.
- R5: When any of the four fault kinds is selected, the bad-address word is loaded with the faulting virtual address at the next clock edge.
- R6: In the cycle a fault is presented, `exc_take` is 1. `exc_vector` is the exception base plus 0x000 when the selected fault is a refill and the flag is 0, and the exception base plus 0x180 in every other case. The default exception base is 0x8000_0000.
- R7: A selected fault loads the exception PC from the fault PC if the flag was 0, and leaves it unchanged if the flag was 1.
- R8: The flag becomes 1 at the clock edge after any selected fault. The flag is cleared by `exc_return`. If a fault and `exc_return` arrive in the same cycle, the fault wins and the flag ends at 1.
- R9: When several faults are presented in one cycle, `exc_cause` reports the winner. The codes are 0 for address error, 1 for refill, 2 for invalid and 3 for modified, and the lowest code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_addr_err | input | 1 | Address-error fault strobe |
| flt_refill | input | 1 | Translation-miss (refill) fault strobe |
| flt_invalid | input | 1 | Invalid-entry fault strobe |
| flt_modified | input | 1 | Write-to-clean-page fault strobe |
| flt_va | input | 32 | Faulting virtual address |
| flt_pc | input | 32 | PC of the faulting instruction |
| exc_return | input | 1 | Exception-return strobe |
| sw_ctx_we | input | 1 | Software write of the context base |
| sw_ctx_data | input | 32 | Software write data (bits 31:23 used) |
| ctx_word | output | 32 | Context word: base, faulting page number, zero low bits |
| bad_va | output | 32 | Last captured faulting virtual address |
| epc | output | 32 | Exception PC |
| exl | output | 1 | Exception-level flag |
| exc_take | output | 1 | A fault is being taken this cycle |
| exc_cause | output | 2 | Code of the selected fault |
| exc_vector | output | 32 | Branch target for the taken fault |

## Verification
The assertions assume that the fault strobes last one cycle and that `flt_va` and `flt_pc` are valid whenever a strobe is high. They also assume that software writes the context word only through `sw_ctx_we`. The directed tasks drive each strobe for exactly one clock, a fixed time after the edge, and return it to zero before the next edge. Every task holds the address and PC for the whole cycle. The stimulus deliberately includes same-cycle collisions: several faults together, a fault with a software write, and a fault with a return. These cases check the arbitration and the separation of the context fields.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
   localparam int N_FAULT = 4;
   typedef enum logic [1:0] {
      CAUSE_ADDR    = 2'd0,
      CAUSE_REFILL  = 2'd1,
      CAUSE_INVALID = 2'd2,
      CAUSE_MODIFY  = 2'd3
   } tfc_cause_e;
endpackage

// File: rtl/tfc_fault_arb.sv
module tfc_fault_arb
   import tfc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FAULT-1:0] req,
   output logic [N_FAULT-1:0] grant,
   output logic               take,
   output tfc_cause_e         cause
);
   genvar gi;
   generate
      for (gi = 0; gi < N_FAULT; gi++) begin : g_pri
         if (gi == 0) begin : g_top
            assign grant[gi] = req[gi];
         end else begin : g_rest
            assign grant[gi] = req[gi] & ~(|req[gi-1:0]);
         end
      end
   endgenerate

   assign take = |req;

   always_comb begin
      cause = CAUSE_ADDR;
      for (int i = N_FAULT - 1; i >= 0; i--) begin
         if (req[i]) cause = tfc_cause_e'(i);
      end
   end

   // R9: exactly one winner whenever any fault is raised
   p_one_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $countones(grant) == 1);
   p_winner_is_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> grant[cause]);
endmodule

// File: rtl/tfc_ctx_reg.sv
module tfc_ctx_reg #(
   parameter int VA_W    = 32,
   parameter int BASE_W  = 9,
   parameter int VPN_LSB = 13
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_we,
   input  logic [VA_W-1:0] sw_data,
   input  logic            hw_we,
   input  logic [VA_W-1:0] va,
   output logic [VA_W-1:0] ctx_q
);
   localparam int VPN_W = VA_W - VPN_LSB;
   localparam int LOW_W = VA_W - BASE_W - VPN_W;

   generate
      if (LOW_W < 1) begin : g_bad_layout
         $error("context layout leaves no aligned low bits");
      end
   endgenerate

   logic [BASE_W-1:0] base_q;
   logic [VPN_W-1:0]  vpn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         vpn_q  <= '0;
      end else begin
         if (sw_we) base_q <= sw_data[VA_W-1 -: BASE_W];
         if (hw_we) vpn_q  <= va[VA_W-1 -: VPN_W];
      end
   end

   assign ctx_q = {base_q, vpn_q, {LOW_W{1'b0}}};

   // R3: page number lands in the middle field one edge later
   p_vpn_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hw_we |=> ctx_q[VA_W-BASE_W-1 -: VPN_W] == $past(va[VA_W-1 -: VPN_W]));
   // R2: base moves only on a software write
   p_base_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_we |=> $stable(ctx_q[VA_W-1 -: BASE_W]));
   // R4: middle field moves only on a context-updating fault
   p_vpn_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_we |=> $stable(ctx_q[VA_W-BASE_W-1 -: VPN_W]));
endmodule

// File: rtl/tfc_exc_ctrl.sv
module tfc_exc_ctrl
   import tfc_pkg::*;
#(
   parameter int              VA_W       = 32,
   parameter logic [VA_W-1:0] EXC_BASE   = 32'h8000_0000,
   parameter int              REFILL_OFS = 'h000,
   parameter int              GEN_OFS    = 'h180
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  tfc_cause_e      cause,
   input  logic [VA_W-1:0] pc,
   input  logic            eret,
   output logic [VA_W-1:0] epc_q,
   output logic            exl_q,
   output logic [VA_W-1:0] vector
);
   generate
      if (REFILL_OFS == GEN_OFS) begin : g_bad_ofs
         $error("refill and general vector offsets must differ");
      end
   endgenerate

   logic use_refill;
   assign use_refill = take && (cause == CAUSE_REFILL) && !exl_q;
   assign vector = EXC_BASE + VA_W'(use_refill ? REFILL_OFS : GEN_OFS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q <= '0;
         exl_q <= 1'b0;
      end else if (take) begin
         exl_q <= 1'b1;
         if (!exl_q) epc_q <= pc;
      end else if (eret) begin
         exl_q <= 1'b0;
      end
   end

   // R7: nested fault keeps the original return point
   p_epc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exl_q) |=> $stable(epc_q));
   p_epc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !exl_q) |=> epc_q == $past(pc));
   // R8: fault raises the flag, plain return lowers it
   p_exl_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> exl_q);
   p_exl_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eret && !take) |=> !exl_q);
   // R6: refill while already in an exception goes to the general entry
   p_nested_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exl_q) |-> vector == EXC_BASE + VA_W'(GEN_OFS));
endmodule

// File: rtl/tlb_fault_ctx.sv
module tlb_fault_ctx
   import tfc_pkg::*;
#(
   parameter int          VA_W       = 32,
   parameter int          BASE_W     = 9,
   parameter int          VPN_LSB    = 13,
   parameter logic [31:0] EXC_BASE   = 32'h8000_0000,
   parameter int          REFILL_OFS = 'h000,
   parameter int          GEN_OFS    = 'h180
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flt_addr_err,
   input  logic            flt_refill,
   input  logic            flt_invalid,
   input  logic            flt_modified,
   input  logic [VA_W-1:0] flt_va,
   input  logic [VA_W-1:0] flt_pc,
   input  logic            exc_return,
   input  logic            sw_ctx_we,
   input  logic [VA_W-1:0] sw_ctx_data,
   output logic [VA_W-1:0] ctx_word,
   output logic [VA_W-1:0] bad_va,
   output logic [VA_W-1:0] epc,
   output logic            exl,
   output logic            exc_take,
   output logic [1:0]      exc_cause,
   output logic [VA_W-1:0] exc_vector
);
   logic [N_FAULT-1:0] req, grant;
   tfc_cause_e         cause;
   logic               ctx_upd;

   assign req = {flt_modified, flt_invalid, flt_refill, flt_addr_err};

   tfc_fault_arb u_arb (
      .clk(clk), .rst_n(rst_n), .req(req),
      .grant(grant), .take(exc_take), .cause(cause)
   );

   assign exc_cause = cause;
   assign ctx_upd   = exc_take && (cause != CAUSE_ADDR);

   tfc_ctx_reg #(.VA_W(VA_W), .BASE_W(BASE_W), .VPN_LSB(VPN_LSB)) u_ctx (
      .clk(clk), .rst_n(rst_n), .sw_we(sw_ctx_we), .sw_data(sw_ctx_data),
      .hw_we(ctx_upd), .va(flt_va), .ctx_q(ctx_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        bad_va <= '0;
      else if (exc_take) bad_va <= flt_va;
   end

   tfc_exc_ctrl #(
      .VA_W(VA_W), .EXC_BASE(VA_W'(EXC_BASE)),
      .REFILL_OFS(REFILL_OFS), .GEN_OFS(GEN_OFS)
   ) u_exc (
      .clk(clk), .rst_n(rst_n), .take(exc_take), .cause(cause),
      .pc(flt_pc), .eret(exc_return),
      .epc_q(epc), .exl_q(exl), .vector(exc_vector)
   );

   // R5: faulting address captured on every fault kind
   p_badva_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> bad_va == $past(flt_va));
   // R4: address error never touches the page-number field
   p_addr_err_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_take && grant[0]) |=> $stable(ctx_word[VA_W-BASE_W-1:0]));
endmodule

// File: tb/tb_tlb_fault_ctx.sv
module tb_tlb_fault_ctx;
   localparam int CLK_P = 10;
   localparam logic [31:0] BASE = 32'h8000_0000;

   logic        clk = 0, rst_n = 0;
   logic        f_ae = 0, f_rf = 0, f_inv = 0, f_mod = 0;
   logic [31:0] va = 0, pc = 0, swd = 0;
   logic        eret = 0, swe = 0;
   logic [31:0] ctx_word, bad_va, epc, exc_vector;
   logic        exl, exc_take;
   logic [1:0]  exc_cause;
   int          n_chk = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   tlb_fault_ctx dut (
      .clk(clk), .rst_n(rst_n), .flt_addr_err(f_ae), .flt_refill(f_rf),
      .flt_invalid(f_inv), .flt_modified(f_mod), .flt_va(va), .flt_pc(pc),
      .exc_return(eret), .sw_ctx_we(swe), .sw_ctx_data(swd),
      .ctx_word(ctx_word), .bad_va(bad_va), .epc(epc), .exl(exl),
      .exc_take(exc_take), .exc_cause(exc_cause), .exc_vector(exc_vector)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_ctx(logic [8:0] b, logic [31:0] a);
      return {b, a[31:13], 4'h0};
   endfunction

   task automatic edge1();
      @(posedge clk); #1;
      {f_ae, f_rf, f_inv, f_mod, eret, swe} = '0;
   endtask

   task automatic t_reset();
      chk("R1 ctx", ctx_word, 0); chk("R1 badva", bad_va, 0);
      chk("R1 epc", epc, 0);      chk("R1 exl", {31'b0, exl}, 0);
   endtask

   task automatic t_sw_write();
      swe = 1; swd = 32'hFFFF_FFFF; edge1();
      chk("R2 base only", ctx_word, 32'hFF80_0000);
   endtask

   task automatic t_first_refill();
      va = 32'h1234_5678; pc = 32'h0040_0100; f_rf = 1; #1;
      chk("R6 take", {31'b0, exc_take}, 1);
      chk("R6 refill vector", exc_vector, BASE);
      chk("R9 cause refill", {30'b0, exc_cause}, 1);
      edge1();
      chk("R3 ctx", ctx_word, mk_ctx(9'h1FF, 32'h1234_5678));
      chk("R5 badva", bad_va, 32'h1234_5678);
      chk("R7 epc load", epc, 32'h0040_0100);
      chk("R8 exl set", {31'b0, exl}, 1);
   endtask

   task automatic t_nested_refill();
      va = 32'h7FFF_E000; pc = 32'h8000_0200; f_rf = 1; #1;
      chk("R6 nested general vector", exc_vector, BASE + 32'h180);
      edge1();
      chk("R7 epc kept", epc, 32'h0040_0100);
      chk("R3 nested ctx", ctx_word, mk_ctx(9'h1FF, 32'h7FFF_E000));
      chk("R5 nested badva", bad_va, 32'h7FFF_E000);
      eret = 1; edge1();
      chk("R8 exl cleared", {31'b0, exl}, 0);
   endtask

   task automatic t_addr_err_wins();
      va = 32'h0ABC_D000; pc = 32'h0000_1000; f_ae = 1; f_rf = 1; #1;
      chk("R9 cause addr", {30'b0, exc_cause}, 0);
      chk("R6 addr general vector", exc_vector, BASE + 32'h180);
      edge1();
      chk("R4 ctx unchanged", ctx_word, mk_ctx(9'h1FF, 32'h7FFF_E000));
      chk("R5 addr badva", bad_va, 32'h0ABC_D000);
      chk("R7 addr epc", epc, 32'h0000_1000);
      eret = 1; edge1();
   endtask

   task automatic t_inv_mod();
      va = 32'h0000_2000; pc = 32'h0000_2004; f_inv = 1; f_mod = 1; #1;
      chk("R9 cause invalid", {30'b0, exc_cause}, 2);
      chk("R6 invalid general", exc_vector, BASE + 32'h180);
      edge1();
      chk("R3 invalid ctx", ctx_word, mk_ctx(9'h1FF, 32'h0000_2000));
      eret = 1; edge1();
      va = 32'hFFFF_FFFF; f_mod = 1; #1;
      chk("R9 cause modified", {30'b0, exc_cause}, 3);
      edge1();
      chk("R3 modified ctx", ctx_word, mk_ctx(9'h1FF, 32'hFFFF_FFFF));
      chk("R5 modified badva", bad_va, 32'hFFFF_FFFF);
   endtask

   task automatic t_collisions();
      // exl is 1 here: fault and return together keep it set (R8)
      va = 32'h0004_6000; f_rf = 1; eret = 1; swe = 1; swd = 32'h0080_0000;
      edge1();
      chk("R8 fault beats return", {31'b0, exl}, 1);
      chk("R2 sw plus fault", ctx_word, mk_ctx(9'h001, 32'h0004_6000));
      eret = 1; edge1();
      chk("R8 return clears", {31'b0, exl}, 0);
   endtask

   initial begin
      fork
         begin
            repeat (2000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      join_none
      repeat (3) @(posedge clk); #1;
      rst_n = 1;
      t_reset();
      t_sw_write();
      t_first_refill();
      t_nested_refill();
      t_addr_err_wins();
      t_inv_mod();
      t_collisions();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule